// File: doc/BRIEF.md
# Streaming K-Point Sum and Lagrange Fold

This block carries out, for one chip, the opening round of a sumcheck variant in which the last variable ranges over K points instead of two. Two passes run over an external stream of field elements. In the sum pass the stream is ordered by the K-valued variable y. The block adds every element into a running sum for the current y and then discards it. It emits each finished sum as soon as the last element of its y group has been taken. In the fold pass the stream is ordered by the boolean index b, with the K values for one b in a row. The block weights each value with a Lagrange coefficient for the challenge point and reduces the group to one element. It writes that element to a local memory port at address b.

The K Lagrange coefficients are computed elsewhere. They are loaded into a small register file through a write port before the fold pass. All arithmetic is modulo a parameterised prime, and every stored or emitted value is fully reduced. Each y group of the sum pass, and so the memory, holds GROUP_LEN entries, which is the per-chip table size divided by K.

Top module: `kpoint_sum_fold`

## Requirements
- R1: While reset is asserted and in the cycle after it, in_ready_o, sum_valid_o and mem_we_o are all 0.
- R2: A sum pass (start_i with pass_i=0) accepts K*GROUP_LEN values. The first GROUP_LEN values belong to y=0, the next GROUP_LEN to y=1, and so on. For each y the block emits one sum_valid_o pulse with sum_idx_o=y and sum_data_o equal to the sum of that group modulo MODULUS.
- R3: The sum for group y appears in the cycle right after the group's last value is accepted, before any value of group y+1 is taken. Each sum is a single-cycle pulse.
- R4: A sum pass makes no memory write.
- R5: A fold pass (start_i with pass_i=1) accepts values grouped by b, with y=0..K-1 consecutive for each b. For each b it writes mem_data_o = sum over y of value(b,y)*weight[y] modulo MODULUS.
- R6: A fold pass makes exactly GROUP_LEN writes, to addresses 0,1,...,GROUP_LEN-1 in that order.
- R7: Weight writes (wt_we_i, wt_idx_i, wt_data_i) mark that entry valid. A sum-pass start clears all marks. During a fold pass in_ready_o stays 0 until all K entries are marked.
- R8: While mem_we_o=1 and mem_ready_i=0, mem_addr_o and mem_data_o hold, mem_we_o stays 1, and in_ready_o is 0.
- R9: Every emitted sum and every written fold value is below MODULUS, given inputs and weights below MODULUS.
- R10: Once a pass has accepted its last value, in_ready_o stays 0 until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a pass; taken only when idle and drained |
| pass_i | input | 1 | Pass chosen at start: 0 sum, 1 fold |
| wt_we_i | input | 1 | Weight register write enable |
| wt_idx_i | input | $clog2(K) | Weight index y |
| wt_data_i | input | DATA_W | Lagrange weight for point y |
| in_valid_i | input | 1 | Stream value valid |
| in_ready_o | output | 1 | Stream value accepted when both high |
| in_data_i | input | DATA_W | Stream value |
| sum_valid_o | output | 1 | One-cycle pulse with a finished group sum |
| sum_idx_o | output | $clog2(K) | y of the emitted sum |
| sum_data_o | output | DATA_W | Group sum modulo MODULUS |
| mem_we_o | output | 1 | Folded value write request |
| mem_ready_i | input | 1 | Memory takes the write when high |
| mem_addr_o | output | $clog2(GROUP_LEN) | Row index b |
| mem_data_o | output | DATA_W | Folded value |

## Verification
A slip in the sum-pass counters shows at once as a sum pulse carrying the wrong index, or firing after the wrong number of accepted values. The bench compares the accepted-value count at each pulse, so the error appears within one group. A wrong accumulator clear or a missed modular reduction corrupts the very next emitted sum or written row, and out-of-range values are caught in that cycle. Faults in the fold pipeline or stall path show at the first memory write as a wrong address, a wrong value or a write request that drops while the memory refuses it. Fold data that reaches the pipeline before the weights are complete shows as in_ready_o rising too early.

// File: rtl/skf_pkg.sv
// Shared definitions for the streaming sum / fold block.
package skf_pkg;
    // Which of the two streaming passes is running.
    typedef enum logic {
        PASS_SUM  = 1'b0,
        PASS_FOLD = 1'b1
    } pass_e;
endpackage

// File: rtl/skf_stream_ctrl.sv
// Stream controller: holds the pass state and the y / b position counters.
// Sum pass walks b fastest inside each y; fold pass walks y fastest inside each b.
// Assumes K and GROUP_LEN are powers of two, at least 2.
module skf_stream_ctrl
    import skf_pkg::*;
#(
    parameter int K         = 32,
    parameter int GROUP_LEN = 4,
    parameter int YW        = 5,
    parameter int BW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          pass_i,
    input  logic          pipe_busy_i,
    input  logic          wts_ok_i,
    input  logic          advance_i,
    input  logic          in_valid_i,
    output logic          in_ready_o,
    output logic          accept_o,
    output logic          clr_wts_o,
    output logic          active_o,
    output pass_e         pass_o,
    output logic [YW-1:0] y_o,
    output logic [BW-1:0] b_o,
    output logic          grp_first_o,
    output logic          grp_last_o
);
    logic          active_q;
    pass_e         pass_q;
    logic [YW-1:0] y_q;
    logic [BW-1:0] b_q;
    logic          y_end, b_end, go;

    assign y_end = (y_q == YW'(K - 1));
    assign b_end = (b_q == BW'(GROUP_LEN - 1));
    // A start is honoured only when no pass runs and the fold pipe is empty.
    assign go    = start_i && !active_q && !pipe_busy_i;

    // Ready: sum pass always takes data; fold pass needs weights and a free pipe.
    assign in_ready_o  = active_q && ((pass_q == PASS_SUM) || (wts_ok_i && advance_i));
    assign accept_o    = in_valid_i && in_ready_o;
    assign clr_wts_o   = go && (pass_e'(pass_i) == PASS_SUM);
    assign grp_first_o = (pass_q == PASS_SUM) ? (b_q == '0) : (y_q == '0);
    assign grp_last_o  = (pass_q == PASS_SUM) ? b_end : y_end;
    assign active_o    = active_q;
    assign pass_o      = pass_q;
    assign y_o         = y_q;
    assign b_o         = b_q;

    // Pass state and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pass_q   <= PASS_SUM;
            y_q      <= '0;
            b_q      <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            pass_q   <= pass_e'(pass_i);
            y_q      <= '0;
            b_q      <= '0;
        end else if (accept_o) begin
            if (pass_q == PASS_SUM) begin
                if (b_end) begin
                    b_q <= '0;
                    if (y_end) active_q <= 1'b0;
                    else       y_q      <= y_q + 1'b1;
                end else begin
                    b_q <= b_q + 1'b1;
                end
            end else begin
                if (y_end) begin
                    y_q <= '0;
                    if (b_end) active_q <= 1'b0;
                    else       b_q      <= b_q + 1'b1;
                end else begin
                    y_q <= y_q + 1'b1;
                end
            end
        end
    end

    // R10: an idle controller never offers ready.
    p_idle_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && grp_last_o && ((pass_q == PASS_SUM) ? y_end : b_end)) |=> !in_ready_o);
endmodule

// File: rtl/skf_weight_regs.sv
// Weight register file: K Lagrange weights with per-entry valid marks.
// A clear drops all marks; a write in the same cycle keeps its own mark.
module skf_weight_regs #(
    parameter int          K      = 32,
    parameter int          DATA_W = 16,
    parameter int unsigned MODULUS = 65521,
    parameter int          YW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [YW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              clr_i,
    input  logic [YW-1:0]     rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              all_ok_o
);
    localparam logic [DATA_W-1:0] MODW = DATA_W'(MODULUS);

    logic [DATA_W-1:0] wt_q [K];
    logic [K-1:0]      ok_q;

    // Store weights and track which entries hold a current value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q <= '0;
            for (int i = 0; i < K; i++) wt_q[i] <= '0;
        end else begin
            for (int i = 0; i < K; i++) begin
                if (wr_en_i && (wr_idx_i == YW'(i))) begin
                    wt_q[i] <= wr_data_i;
                    ok_q[i] <= 1'b1;
                end else if (clr_i) begin
                    ok_q[i] <= 1'b0;
                end
            end
        end
    end

    assign rd_data_o = wt_q[rd_idx_i];
    assign all_ok_o  = &ok_q;

    // R9: weights must arrive already reduced.
    p_wt_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_data_i < MODW));
endmodule

// File: rtl/skf_sum_acc.sv
// Sum-pass accumulator: one running modular sum, restarted at each y group,
// emitted as a one-cycle pulse when the group's last value is taken.
module skf_sum_acc #(
    parameter int          DATA_W  = 16,
    parameter int unsigned MODULUS = 65521,
    parameter int          YW      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              first_i,
    input  logic              last_i,
    input  logic [YW-1:0]     y_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sum_valid_o,
    output logic [YW-1:0]     sum_idx_o,
    output logic [DATA_W-1:0] sum_data_o
);
    localparam logic [DATA_W:0] MODX = (DATA_W + 1)'(MODULUS);

    logic [DATA_W-1:0] acc_q, acc_nxt;
    logic [DATA_W:0]   raw;

    // Modular add of the running sum and the new value.
    always_comb begin
        raw = {1'b0, acc_q} + {1'b0, data_i};
        if (first_i)          acc_nxt = data_i;
        else if (raw >= MODX) acc_nxt = DATA_W'(raw - MODX);
        else                  acc_nxt = raw[DATA_W-1:0];
    end

    // Running sum and emitted result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            sum_valid_o <= 1'b0;
            sum_idx_o   <= '0;
            sum_data_o  <= '0;
        end else begin
            sum_valid_o <= fire_i && last_i;
            if (fire_i) begin
                acc_q <= acc_nxt;
                if (last_i) begin
                    sum_idx_o  <= y_i;
                    sum_data_o <= acc_nxt;
                end
            end
        end
    end

    // R9: an emitted sum is fully reduced.
    p_sum_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |-> ({1'b0, sum_data_o} < MODX));
    // R3: each sum is a single-cycle pulse.
    p_sum_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid_o |=> !sum_valid_o);
endmodule

// File: rtl/skf_mac_pipe.sv
// Fold pipeline: multiply, reduce, accumulate, write.
// Stage 1 forms the full product, stage 2 reduces it modulo MODULUS,
// stage 3 adds it into the b-group accumulator and on the group's last
// value parks the result in a write register. A refused write freezes
// every stage, and the controller drops ready on the same condition.
module skf_mac_pipe #(
    parameter int          DATA_W  = 16,
    parameter int unsigned MODULUS = 65521,
    parameter int          BW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic              last_i,
    input  logic [BW-1:0]     b_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] wt_i,
    input  logic              mem_ready_i,
    output logic              advance_o,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [BW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);
    localparam int                  PW   = 2 * DATA_W;
    localparam logic [PW-1:0]       MODP = PW'(MODULUS);
    localparam logic [DATA_W:0]     MODX = (DATA_W + 1)'(MODULUS);

    logic              v1_q, last1_q, v2_q, last2_q, open_q;
    logic [BW-1:0]     b1_q, b2_q;
    logic [PW-1:0]     prod1_q;
    logic [DATA_W-1:0] red2_q, acc_q, acc_nxt;
    logic [DATA_W:0]   raw;

    assign advance_o = !(mem_we_o && !mem_ready_i);
    assign busy_o    = v1_q || v2_q || mem_we_o || open_q;

    // Accumulate the reduced product, restarting after a group ends.
    always_comb begin
        raw = {1'b0, acc_q} + {1'b0, red2_q};
        if (!open_q)          acc_nxt = red2_q;
        else if (raw >= MODX) acc_nxt = DATA_W'(raw - MODX);
        else                  acc_nxt = raw[DATA_W-1:0];
    end

    // Stage 1: full-width product of value and weight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            last1_q <= 1'b0;
            b1_q    <= '0;
            prod1_q <= '0;
        end else if (advance_o) begin
            v1_q    <= fire_i;
            last1_q <= last_i;
            b1_q    <= b_i;
            prod1_q <= {{DATA_W{1'b0}}, data_i} * {{DATA_W{1'b0}}, wt_i};
        end
    end

    // Stage 2: reduce the product modulo the prime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q    <= 1'b0;
            last2_q <= 1'b0;
            b2_q    <= '0;
            red2_q  <= '0;
        end else if (advance_o) begin
            v2_q    <= v1_q;
            last2_q <= last1_q;
            b2_q    <= b1_q;
            red2_q  <= DATA_W'(prod1_q % MODP);
        end
    end

    // Stage 3: group accumulator and the parked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            open_q     <= 1'b0;
            mem_we_o   <= 1'b0;
            mem_addr_o <= '0;
            mem_data_o <= '0;
        end else if (advance_o) begin
            if (mem_we_o && mem_ready_i) mem_we_o <= 1'b0;
            if (v2_q) begin
                acc_q  <= acc_nxt;
                open_q <= !last2_q;
                if (last2_q) begin
                    mem_we_o   <= 1'b1;
                    mem_addr_o <= b2_q;
                    mem_data_o <= acc_nxt;
                end
            end
        end
    end

    // R8: a refused write holds its request, address and data.
    p_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !mem_ready_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_data_o)));
    // R9: a written fold value is fully reduced.
    p_fold_reduced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ({1'b0, mem_data_o} < MODX));
endmodule

// File: rtl/kpoint_sum_fold.sv
// Top level: streaming K-point group sums (sum pass) and Lagrange-weighted
// fold into local memory (fold pass) over one valid/ready input stream.
// Assumes inputs below MODULUS; start is issued only between passes.
module kpoint_sum_fold
    import skf_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int unsigned MODULUS   = 65521,
    parameter int          K         = 32,
    parameter int          GROUP_LEN = 4,
    localparam int         YW        = $clog2(K),
    localparam int         BW        = $clog2(GROUP_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pass_i,
    input  logic              wt_we_i,
    input  logic [YW-1:0]     wt_idx_i,
    input  logic [DATA_W-1:0] wt_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              sum_valid_o,
    output logic [YW-1:0]     sum_idx_o,
    output logic [DATA_W-1:0] sum_data_o,
    output logic              mem_we_o,
    input  logic              mem_ready_i,
    output logic [BW-1:0]     mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o
);
    logic              accept, clr_wts, active, advance, pipe_busy, wts_ok;
    logic              grp_first, grp_last;
    pass_e             pass_cur;
    logic [YW-1:0]     y_pos;
    logic [BW-1:0]     b_pos;
    logic [DATA_W-1:0] wt_rd;

    skf_stream_ctrl #(.K(K), .GROUP_LEN(GROUP_LEN), .YW(YW), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pass_i(pass_i),
        .pipe_busy_i(pipe_busy), .wts_ok_i(wts_ok), .advance_i(advance),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .accept_o(accept),
        .clr_wts_o(clr_wts), .active_o(active), .pass_o(pass_cur),
        .y_o(y_pos), .b_o(b_pos), .grp_first_o(grp_first), .grp_last_o(grp_last)
    );

    skf_weight_regs #(.K(K), .DATA_W(DATA_W), .MODULUS(MODULUS), .YW(YW)) u_wts (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wt_we_i), .wr_idx_i(wt_idx_i),
        .wr_data_i(wt_data_i), .clr_i(clr_wts), .rd_idx_i(y_pos),
        .rd_data_o(wt_rd), .all_ok_o(wts_ok)
    );

    skf_sum_acc #(.DATA_W(DATA_W), .MODULUS(MODULUS), .YW(YW)) u_sum (
        .clk(clk), .rst_n(rst_n), .fire_i(accept && (pass_cur == PASS_SUM)),
        .first_i(grp_first), .last_i(grp_last), .y_i(y_pos), .data_i(in_data_i),
        .sum_valid_o(sum_valid_o), .sum_idx_o(sum_idx_o), .sum_data_o(sum_data_o)
    );

    skf_mac_pipe #(.DATA_W(DATA_W), .MODULUS(MODULUS), .BW(BW)) u_mac (
        .clk(clk), .rst_n(rst_n), .fire_i(accept && (pass_cur == PASS_FOLD)),
        .last_i(grp_last), .b_i(b_pos), .data_i(in_data_i), .wt_i(wt_rd),
        .mem_ready_i(mem_ready_i), .advance_o(advance), .busy_o(pipe_busy),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
    );

    // R1: reset leaves every output handshake quiet.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!in_ready_o && !sum_valid_o && !mem_we_o));
    // R4: the sum pass never writes memory.
    p_no_write_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (pass_cur == PASS_SUM)) |-> !mem_we_o);
    // R7: fold data is not taken before every weight is loaded.
    p_wait_weights_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && (pass_cur == PASS_FOLD)) |-> wts_ok);
endmodule

// File: tb/tb_kpoint_sum_fold.sv
module tb_kpoint_sum_fold;
    localparam int          DW  = 16;
    localparam int unsigned MOD = 65521;
    localparam int          K   = 32;
    localparam int          GL  = 4;
    localparam int          YW  = $clog2(K);
    localparam int          BW  = $clog2(GL);

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, pass_sel = 1'b0;
    logic wt_we = 1'b0;
    logic [YW-1:0] wt_idx = '0;
    logic [DW-1:0] wt_data = '0;
    logic in_valid = 1'b0, in_ready;
    logic [DW-1:0] in_data = '0;
    logic sum_valid;
    logic [YW-1:0] sum_idx;
    logic [DW-1:0] sum_data;
    logic mem_we, mem_ready = 1'b1;
    logic [BW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int tests = 0, fails = 0;
    int accepted = 0;
    int sum_cnt = 0, wr_cnt = 0, stall_err = 0;
    int sum_i [K];
    int sum_d [K];
    int sum_at [K];
    int wr_a [GL];
    int wr_d [GL];
    longint wts [K];
    logic hold_prev = 1'b0;
    logic [BW-1:0] hold_a;
    logic [DW-1:0] hold_d;

    always #4 clk = ~clk;

    kpoint_sum_fold #(.DATA_W(DW), .MODULUS(MOD), .K(K), .GROUP_LEN(GL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pass_i(pass_sel),
        .wt_we_i(wt_we), .wt_idx_i(wt_idx), .wt_data_i(wt_data),
        .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
        .sum_valid_o(sum_valid), .sum_idx_o(sum_idx), .sum_data_o(sum_data),
        .mem_we_o(mem_we), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr),
        .mem_data_o(mem_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitors, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sum_valid) begin
                if (sum_cnt < K) begin
                    sum_i[sum_cnt]  = int'(sum_idx);
                    sum_d[sum_cnt]  = int'(sum_data);
                    sum_at[sum_cnt] = accepted;
                end
                sum_cnt++;
            end
            if (hold_prev && !(mem_we && mem_addr == hold_a && mem_data == hold_d))
                stall_err++;
            if (mem_we && !mem_ready && in_ready) stall_err++;
            hold_prev = mem_we && !mem_ready;
            hold_a    = mem_addr;
            hold_d    = mem_data;
            if (mem_we && mem_ready) begin
                if (wr_cnt < GL) begin
                    wr_a[wr_cnt] = int'(mem_addr);
                    wr_d[wr_cnt] = int'(mem_data);
                end
                wr_cnt++;
            end
        end
    end

    task automatic send(input logic [DW-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        accepted++;
        in_valid = 1'b0;
    endtask

    task automatic start_pass(input logic p);
        start = 1'b1; pass_sel = p;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic write_wt(input int y, input longint v);
        wt_we = 1'b1; wt_idx = YW'(y); wt_data = DW'(v);
        @(posedge clk); #1;
        wt_we = 1'b0;
    endtask

    task automatic clear_mon();
        sum_cnt = 0; wr_cnt = 0; stall_err = 0; accepted = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic longint sval(input int pat, input int y, input int b);
        if (pat == 0) return longint'(y * 100 + b + 1);
        return longint'(MOD - 1 - b);
    endfunction

    function automatic longint fval(input int pat, input int b, input int y);
        return longint'((b * 1000 + y * 37 + pat * 5003 + 5) % MOD);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 in_ready", in_ready, 0);
        check("R1 sum_valid", sum_valid, 0);
        check("R1 mem_we", mem_we, 0);
    endtask

    task automatic t_sum(input int pat);
        int ok_val = 0, ok_at = 0, ok_rng = 0, blocked = 0;
        clear_mon();
        start_pass(1'b0);
        for (int y = 0; y < K; y++)
            for (int b = 0; b < GL; b++) send(DW'(sval(pat, y, b)));
        idle(4);
        check("R2 sum count", sum_cnt, K);
        for (int y = 0; y < K; y++) begin
            longint e = 0;
            for (int b = 0; b < GL; b++) e = (e + sval(pat, y, b)) % MOD;
            if (sum_i[y] == y && longint'(sum_d[y]) == e) ok_val++;
            else $display("FAIL R2 y=%0d actual idx=%0d val=%0d expected val=%0d",
                          y, sum_i[y], sum_d[y], e);
            if (sum_at[y] == (y + 1) * GL) ok_at++;
            else $display("FAIL R3 y=%0d actual accepted=%0d expected=%0d",
                          y, sum_at[y], (y + 1) * GL);
            if (sum_d[y] < int'(MOD)) ok_rng++;
        end
        check("R2 sums", ok_val, K);
        check("R3 early emit", ok_at, K);
        check("R9 sums reduced", ok_rng, K);
        check("R4 no writes", wr_cnt, 0);
        in_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (in_ready) blocked++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        check("R10 ready after pass", blocked, 0);
    endtask

    task automatic fold_run(input int pat, input bit stall);
        int ok_v = 0, ok_a = 0;
        clear_mon();
        if (stall) begin
            fork
                for (int b = 0; b < GL; b++)
                    for (int y = 0; y < K; y++) send(DW'(fval(pat, b, y)));
                for (int i = 0; i < 300; i++) begin
                    @(posedge clk); #1;
                    mem_ready = ((i % 7) < 3) ? 1'b0 : 1'b1;
                end
            join
            mem_ready = 1'b1;
        end else begin
            for (int b = 0; b < GL; b++)
                for (int y = 0; y < K; y++) send(DW'(fval(pat, b, y)));
        end
        idle(10);
        check("R6 write count", wr_cnt, GL);
        for (int b = 0; b < GL; b++) begin
            longint e = 0;
            for (int y = 0; y < K; y++) e = (e + fval(pat, b, y) * wts[y]) % MOD;
            if (wr_a[b] == b) ok_a++;
            else $display("FAIL R6 write %0d actual addr=%0d expected=%0d", b, wr_a[b], b);
            if (longint'(wr_d[b]) == e) ok_v++;
            else $display("FAIL R5 b=%0d actual=%0d expected=%0d", b, wr_d[b], e);
        end
        check("R5 folded values", ok_v, GL);
        check("R6 address order", ok_a, GL);
        if (stall) check("R8 stall hold", stall_err, 0);
    endtask

    task automatic t_fold_wait();
        int early = 0;
        for (int y = 0; y < K - 1; y++) write_wt(y, wts[y]);
        start_pass(1'b1);
        in_valid = 1'b1; in_data = DW'(fval(0, 0, 0));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (in_ready) early++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        check("R7 ready held low", early, 0);
        write_wt(K - 1, wts[K - 1]);
        fold_run(0, 1'b0);
    endtask

    task automatic t_fold_stall();
        start_pass(1'b1);
        fold_run(1, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int y = 0; y < K; y++) wts[y] = longint'((y * 7919 + 3) % MOD);
        wts[K - 1] = MOD - 1;
        repeat (3) @(posedge clk);
        t_reset();
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);
        t_sum(0);
        idle(4);
        t_sum(1);
        idle(4);
        t_fold_wait();
        idle(4);
        t_fold_stall();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule